// File: doc/BRIEF.md
# Banked Byte-Lane Memory

This block is the memory side of a 16-bit processor bus that multiplexes address and data and uses a 20-bit byte address. During the address phase, the address-enable strobe captures the low 16 address bits from the shared lines. In the same cycle it captures the four upper address bits, the memory/IO flag and the active-low high-byte enable. In the data phase that follows, the same 16 lines carry write data, or the cycle asks for read data.

The captured address is decoded into bank-pair selects by a 3-to-8 decode. That decode only acts in a memory cycle and only when every address bit above the decoded field is zero. Storage is split into an even byte array and an odd byte array for each pair. The even array holds data bits 7..0 and is enabled by address bit 0 being low. The odd array holds bits 15..8 and is enabled by the high-byte enable. Each array is indexed by address bits `ARR_AW..1`.

With `ARR_AW = 14`, each array is 16K x 8. The decode field is then bits 17..15, the pairs cover 00000h-07FFFh and 08000h-0FFFFh, and the total is 64 KB. The default build uses `ARR_AW = 9`, which keeps the arrays small enough for block RAM tests. Write enables are per lane, and reads come back one clock after the read strobe.

Top module: `byte_lane_mem`

## Requirements
- R1: A synchronous active-high reset clears `rd_lane_oe` to 2'b00 and `rd_data` to 0 on the next clock edge.
- R2: A clock edge with `ale` = 1 captures `{a_hi, ad_in}` as the 20-bit address, together with `is_mem` and `hbe_n`. Bus values in later cycles do not change the captured address until the next `ale` edge.
- R3: The even lane (data bits 7..0) is accessed only when captured address bit 0 is 0.
- R4: The odd lane (data bits 15..8) is accessed only when the captured `hbe_n` is 0.
- R5: Each array is indexed by address bits `ARR_AW..1`. Address bit 0 never reaches the arrays, so a byte at odd address x shares its index with even address x-1.
- R6: Pair p is selected when `is_mem` = 1, bits 19..`ARR_AW`+4 are all 0, and bits `ARR_AW`+3..`ARR_AW`+1 equal p. Only decoder outputs 0 and 1 have a pair, so pair 0 holds the lowest 2^(`ARR_AW`+1) bytes and pair 1 the next block.
- R7: A word access (bit 0 = 0, `hbe_n` = 0) transfers both bytes in one data-phase cycle. For such a read, `rd_lane_oe` is 2'b11.
- R8: An I/O cycle (`is_mem` = 0), or an address outside both pairs, writes no array and returns `rd_lane_oe` = 2'b00.
- R9: With bit 0 = 1 and `hbe_n` = 1, neither lane is accessed. Nothing is written, and a read returns `rd_lane_oe` = 2'b00.
- R10: A read strobe at edge k yields `rd_data` and `rd_lane_oe` after edge k+1. Each `rd_lane_oe` bit (bit 0 even, bit 1 odd) is 1 only in that cycle. A lane whose enable bit is 0 reads as 8'h00.
- R11: A read or write strobe presented in the same cycle as `ale` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Address-phase strobe |
| is_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| hbe_n | input | 1 | Active-low high-byte enable |
| a_hi | input | 4 | Address bits 19..16 |
| ad_in | input | 16 | Multiplexed address/data lines |
| rd | input | 1 | Read strobe (data phase) |
| wr | input | 1 | Write strobe (data phase) |
| rd_data | output | 16 | Read data, disabled lanes forced to 0 |
| rd_lane_oe | output | 2 | Per-lane read drive enable {odd, even} |

## Verification
A word access makes both lane functions act in one cycle: the even-lane write and the odd-lane write share a single strobe, each gated by its own condition. This is provoked by a full sweep of word writes at every mapped even address. It is judged by reading the same locations back as words, and again as separate byte reads at even and odd addresses, all against a byte-level reference model. Byte writes mixed in afterwards confirm that one lane's strobe leaves the neighbouring byte untouched.

// File: rtl/bl_pkg.sv
package bl_pkg;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              hbe_n;
    logic              mem;
  } bus_addr_t;
endpackage

// File: rtl/bl_addr_latch.sv
module bl_addr_latch
  import bl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ale,
  input  logic              is_mem,
  input  logic              hbe_n,
  input  logic [3:0]        a_hi,
  input  logic [DATA_W-1:0] ad_in,
  output bus_addr_t         lat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lat.addr  <= '0;
      lat.hbe_n <= 1'b1;
      lat.mem   <= 1'b0;
    end else if (ale) begin
      lat.addr  <= {a_hi, ad_in};
      lat.hbe_n <= hbe_n;
      lat.mem   <= is_mem;
    end
  end
endmodule

// File: rtl/bl_pair_decode.sv
module bl_pair_decode
  import bl_pkg::*;
#(
  parameter int ARR_AW    = 9,
  parameter int NUM_PAIRS = 2
) (
  input  bus_addr_t              lat,
  output logic [NUM_PAIRS-1:0]   pair_sel,
  output logic                   hit
);
  localparam int FLD_LO = ARR_AW + 1;
  localparam int FLD_HI = ARR_AW + 3;
  localparam int TOP_LO = ARR_AW + 4;

  logic [2:0] field;
  logic       upper_zero;
  logic       dec_en;
  logic [7:0] dec_out;

  always_comb begin
    field      = lat.addr[FLD_HI:FLD_LO];
    upper_zero = (lat.addr[ADDR_W-1:TOP_LO] == '0);
    dec_en     = lat.mem & upper_zero;
    for (int i = 0; i < 8; i++) begin
      dec_out[i] = dec_en && (field == 3'(i));
    end
  end

  assign pair_sel = dec_out[NUM_PAIRS-1:0];
  assign hit      = |pair_sel;
endmodule

// File: rtl/bl_byte_ram.sv
module bl_byte_ram #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) q <= mem[idx];
  end
endmodule

// File: rtl/byte_lane_mem.sv
module byte_lane_mem
  import bl_pkg::*;
#(
  parameter int ARR_AW    = 9,
  parameter int NUM_PAIRS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale,
  input  logic              is_mem,
  input  logic              hbe_n,
  input  logic [3:0]        a_hi,
  input  logic [DATA_W-1:0] ad_in,
  input  logic              rd,
  input  logic              wr,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        rd_lane_oe
);
  localparam int PAIR_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1;
  localparam int LANE_W = DATA_W / 2;

  bus_addr_t             lat;
  logic [NUM_PAIRS-1:0]  pair_sel;
  logic                  any_hit;
  logic                  lat_a0;
  logic                  lat_hbe_n;
  logic [ARR_AW-1:0]     idx;
  logic                  rd_go, wr_go;
  logic                  lo_ok, hi_ok;
  logic [PAIR_W-1:0]     pair_idx;
  logic [PAIR_W-1:0]     pair_q;
  logic [1:0]            oe_q;
  logic [LANE_W-1:0]     q_lo [NUM_PAIRS];
  logic [LANE_W-1:0]     q_hi [NUM_PAIRS];

  bl_addr_latch u_latch (
    .clk    (clk),
    .rst    (rst),
    .ale    (ale),
    .is_mem (is_mem),
    .hbe_n  (hbe_n),
    .a_hi   (a_hi),
    .ad_in  (ad_in),
    .lat    (lat)
  );

  bl_pair_decode #(.ARR_AW(ARR_AW), .NUM_PAIRS(NUM_PAIRS)) u_dec (
    .lat      (lat),
    .pair_sel (pair_sel),
    .hit      (any_hit)
  );

  assign lat_a0    = lat.addr[0];
  assign lat_hbe_n = lat.hbe_n;
  assign idx       = lat.addr[ARR_AW:1];
  assign rd_go     = rd & ~ale;
  assign wr_go     = wr & ~ale;
  assign lo_ok     = ~lat_a0;
  assign hi_ok     = ~lat_hbe_n;

  always_comb begin
    pair_idx = '0;
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (pair_sel[p]) pair_idx = PAIR_W'(p);
    end
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    bl_byte_ram #(.AW(ARR_AW), .DW(LANE_W)) u_even (
      .clk   (clk),
      .we    (wr_go & pair_sel[p] & lo_ok),
      .re    (rd_go & pair_sel[p] & lo_ok),
      .idx   (idx),
      .wdata (ad_in[LANE_W-1:0]),
      .q     (q_lo[p])
    );
    bl_byte_ram #(.AW(ARR_AW), .DW(LANE_W)) u_odd (
      .clk   (clk),
      .we    (wr_go & pair_sel[p] & hi_ok),
      .re    (rd_go & pair_sel[p] & hi_ok),
      .idx   (idx),
      .wdata (ad_in[DATA_W-1:LANE_W]),
      .q     (q_hi[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q   <= 2'b00;
      pair_q <= '0;
    end else begin
      oe_q   <= rd_go ? {any_hit & hi_ok, any_hit & lo_ok} : 2'b00;
      if (rd_go) pair_q <= pair_idx;
    end
  end

  assign rd_lane_oe = oe_q;
  assign rd_data    = {oe_q[1] ? q_hi[pair_q] : {LANE_W{1'b0}},
                       oe_q[0] ? q_lo[pair_q] : {LANE_W{1'b0}}};
endmodule

// File: rtl/byte_lane_mem_chk.sv
module byte_lane_mem_chk (
  input logic        clk,
  input logic        rst,
  input logic        ale,
  input logic        rd,
  input logic [15:0] rd_data,
  input logic [1:0]  rd_lane_oe,
  input logic        lat_a0,
  input logic        lat_hbe_n,
  input logic        hit
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (rd_lane_oe == 2'b00)); // R1
  AST_EVEN_GATE: assert property (@(posedge clk) disable iff (rst) rd_lane_oe[0] |-> !$past(lat_a0)); // R3
  AST_ODD_GATE: assert property (@(posedge clk) disable iff (rst) rd_lane_oe[1] |-> !$past(lat_hbe_n)); // R4
  AST_WORD_BOTH: assert property (@(posedge clk) disable iff (rst) (rd && !ale && hit && !lat_a0 && !lat_hbe_n) |=> (rd_lane_oe == 2'b11)); // R7
  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (rst) (rd && !ale && !hit) |=> (rd_lane_oe == 2'b00)); // R8
  AST_NO_LANE: assert property (@(posedge clk) disable iff (rst) (rd && !ale && lat_a0 && lat_hbe_n) |=> (rd_lane_oe == 2'b00)); // R9
  AST_OE_AFTER_READ: assert property (@(posedge clk) disable iff (rst) (|rd_lane_oe) |-> $past(rd && !ale)); // R10 R11
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst) (rd_lane_oe == 2'b00) |-> (rd_data == 16'h0000)); // R10
endmodule

bind byte_lane_mem byte_lane_mem_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .ale        (ale),
  .rd         (rd),
  .rd_data    (rd_data),
  .rd_lane_oe (rd_lane_oe),
  .lat_a0     (lat_a0),
  .lat_hbe_n  (lat_hbe_n),
  .hit        (any_hit)
);

// File: tb/test_byte_lane_mem.sv
module test_byte_lane_mem;
  localparam int CLK_PERIOD = 10;
  localparam int ARR_AW     = 9;
  localparam int MAP_BYTES  = 2 * 2 * (1 << ARR_AW);
  localparam int WDOG_LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ale = 1'b0;
  logic        is_mem = 1'b1;
  logic        hbe_n = 1'b1;
  logic [3:0]  a_hi = '0;
  logic [15:0] ad_in = '0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] rd_data;
  logic [1:0]  rd_lane_oe;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [7:0] ref_mem [MAP_BYTES];

  byte_lane_mem #(.ARR_AW(ARR_AW), .NUM_PAIRS(2)) i_byte_lane_mem (
    .clk(clk), .rst(rst), .ale(ale), .is_mem(is_mem), .hbe_n(hbe_n),
    .a_hi(a_hi), .ad_in(ad_in), .rd(rd), .wr(wr),
    .rd_data(rd_data), .rd_lane_oe(rd_lane_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WDOG_LIMIT) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles, expected fewer than %0d", cyc, WDOG_LIMIT);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic logic [15:0] pat(input logic [19:0] a, input logic [7:0] salt);
    return {a[8:1] ^ salt, a[10:3] + salt + 8'h3C};
  endfunction

  function automatic logic mapped(input logic [19:0] a, input logic m);
    return m && (a < 20'(MAP_BYTES));
  endfunction

  function automatic logic [17:0] expect_rd(input logic [19:0] a, input logic hn, input logic m);
    logic lo, hi;
    int base;
    logic [7:0] b_lo, b_hi;
    lo = mapped(a, m) && !a[0];
    hi = mapped(a, m) && !hn;
    base = int'({a[19:1], 1'b0});
    b_lo = lo ? ref_mem[base] : 8'h00;
    b_hi = hi ? ref_mem[base + 1] : 8'h00;
    return {hi, lo, b_hi, b_lo};
  endfunction

  task automatic ref_write(input logic [19:0] a, input logic hn, input logic m, input logic [15:0] d);
    int base;
    base = int'({a[19:1], 1'b0});
    if (mapped(a, m)) begin
      if (!a[0]) ref_mem[base] = d[7:0];
      if (!hn)   ref_mem[base + 1] = d[15:8];
    end
  endtask

  task automatic access(input logic [19:0] a, input logic hn, input logic m,
                        input logic is_wr, input logic [15:0] d, output logic [17:0] got);
    @(negedge clk);
    ale = 1'b1; a_hi = a[19:16]; ad_in = a[15:0]; hbe_n = hn; is_mem = m;
    rd = 1'b0; wr = 1'b0;
    @(negedge clk);
    ale = 1'b0;
    ad_in = is_wr ? d : ~a[15:0];
    hbe_n = ~hn; is_mem = ~m; a_hi = ~a[19:16];
    rd = !is_wr; wr = is_wr;
    @(negedge clk);
    got = {rd_lane_oe, rd_data};
    rd = 1'b0; wr = 1'b0;
  endtask

  task automatic do_wr(input logic [19:0] a, input logic hn, input logic m, input logic [15:0] d);
    logic [17:0] g;
    access(a, hn, m, 1'b1, d, g);
    ref_write(a, hn, m, d);
  endtask

  task automatic chk_rd(input string req, input logic [19:0] a, input logic hn, input logic m);
    logic [17:0] g, e;
    e = expect_rd(a, hn, m);
    access(a, hn, m, 1'b0, 16'h0000, g);
    n_chk++;
    if (g !== e) begin
      n_fail++;
      $display("FAIL %s addr=%05h hbe_n=%0b mem=%0b: got oe=%b data=%04h, expected oe=%b data=%04h",
               req, a, hn, m, g[17:16], g[15:0], e[17:16], e[15:0]);
    end
  endtask

  task automatic chk_val(input string req, input logic [17:0] g, input logic [17:0] e);
    n_chk++;
    if (g !== e) begin
      n_fail++;
      $display("FAIL %s: got %05h, expected %05h", req, g, e);
    end
  endtask

  initial begin
    for (int i = 0; i < MAP_BYTES; i++) ref_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk_val("R1 reset outputs", {rd_lane_oe, rd_data}, 18'h0);
    rst = 1'b0;

    // R7: word writes fill both lanes of every mapped location
    for (int a = 0; a < MAP_BYTES; a += 2) do_wr(20'(a), 1'b0, 1'b1, pat(20'(a), 8'hA5));
    // R2 R3 R4 R5 R6 R7: word read-back sweep, data phase drives a different value on the bus
    for (int a = 0; a < MAP_BYTES; a += 2) chk_rd("R7 word read", 20'(a), 1'b0, 1'b1);

    // R4: odd byte writes, R3: even byte writes
    for (int a = 1; a < MAP_BYTES; a += 6) do_wr(20'(a), 1'b0, 1'b1, pat(20'(a), 8'h17));
    for (int a = 0; a < MAP_BYTES; a += 10) do_wr(20'(a), 1'b1, 1'b1, pat(20'(a), 8'hC3));
    for (int a = 0; a < MAP_BYTES; a += 2) chk_rd("R3 R4 R5 word after byte writes", 20'(a), 1'b0, 1'b1);
    for (int a = 1; a < MAP_BYTES; a += 14) chk_rd("R4 odd byte read", 20'(a), 1'b0, 1'b1);
    for (int a = 0; a < MAP_BYTES; a += 14) chk_rd("R3 even byte read", 20'(a), 1'b1, 1'b1);

    // R6: around the pair boundary
    chk_rd("R6 last word of pair 0", 20'(MAP_BYTES/2 - 2), 1'b0, 1'b1);
    chk_rd("R6 last odd byte of pair 0", 20'(MAP_BYTES/2 - 1), 1'b0, 1'b1);
    chk_rd("R6 first word of pair 1", 20'(MAP_BYTES/2), 1'b0, 1'b1);
    chk_rd("R6 first even byte of pair 1", 20'(MAP_BYTES/2), 1'b1, 1'b1);
    chk_rd("R6 last word of pair 1", 20'(MAP_BYTES - 2), 1'b0, 1'b1);

    // R8: unmapped space and I/O cycles
    do_wr(20'(MAP_BYTES), 1'b0, 1'b1, 16'hDEAD);
    do_wr(20'h10004, 1'b0, 1'b1, 16'hBEEF);
    do_wr(20'h80006, 1'b0, 1'b1, 16'hCAFE);
    do_wr(20'h00008, 1'b0, 1'b0, 16'hF00D);
    chk_rd("R8 read unmapped decoder out 2", 20'(MAP_BYTES), 1'b0, 1'b1);
    chk_rd("R8 read above decoded window", 20'h10004, 1'b0, 1'b1);
    chk_rd("R8 read high unmapped", 20'h80006, 1'b0, 1'b1);
    chk_rd("R8 io read", 20'h00008, 1'b0, 1'b0);
    chk_rd("R8 no alias at 0", 20'h00000, 1'b0, 1'b1);
    chk_rd("R8 no alias at 4", 20'h00004, 1'b0, 1'b1);
    chk_rd("R8 no alias at 6", 20'h00006, 1'b0, 1'b1);
    chk_rd("R8 io write left memory unchanged", 20'h00008, 1'b0, 1'b1);

    // R9: neither lane
    do_wr(20'h00021, 1'b1, 1'b1, 16'h1234);
    chk_rd("R9 read with no lane", 20'h00021, 1'b1, 1'b1);
    chk_rd("R9 word unchanged", 20'h00020, 1'b0, 1'b1);

    // R11: write strobe during the address phase is ignored
    @(negedge clk);
    ale = 1'b1; a_hi = 4'h0; ad_in = 16'h0030; hbe_n = 1'b0; is_mem = 1'b1; wr = 1'b1;
    @(negedge clk);
    ale = 1'b0; wr = 1'b0;
    chk_rd("R11 write with ale ignored", 20'h00030, 1'b0, 1'b1);
    // R11 / R10: read strobe during address phase gives no output
    @(negedge clk);
    ale = 1'b1; ad_in = 16'h0030; rd = 1'b1;
    @(negedge clk);
    chk_val("R11 read with ale ignored", {rd_lane_oe, rd_data}, 18'h0);
    ale = 1'b0; rd = 1'b0;
    @(negedge clk);
    chk_val("R10 idle outputs zero", {rd_lane_oe, rd_data}, 18'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule